// File: doc/BRIEF.md
# Interrupt Pin Request and End-of-Interrupt Tracker

This block watches a set of interrupt input pins and decides, one cycle at a time, which pin should be handed to a downstream dispatcher for delivery. Each pin has its own polarity, trigger kind (edge or level), mask bit and interrupt vector. These come from a redirection table held elsewhere. The block keeps a request bit for every pin. For level-triggered pins it also keeps an "in service at the remote end" flag (remote IRR). The flag blocks any further delivery until an end-of-interrupt (EOI) message releases it.

When a pin needs service, the block raises a service request carrying the pin number and its vector. In the same cycle the dispatcher answers with a delivered / not-delivered result. An EOI strobe carries a vector and releases every level-triggered pin programmed with that vector. A released pin whose input is still active is served again without a new edge. Resolving the destination of a delivery is left to the dispatcher.

Top module: `irq_trk`

## Requirements
- R1: While reset is held and in the first cycle after it, `svc_valid` is 0 and every bit of `rirr` is 0.
- R2: The effective level of pin i is `pin_raw[i] XOR pin_pol[i]`. With `pin_pol[i]`=1 a low raw input is active and a high raw input is inactive.
- R3: An inactive effective level clears the pin's request bit. An edge request that goes inactive before it is granted is never served.
- R4: An edge pin (`pin_trig_lvl[i]`=0) is served exactly once for each 0-to-1 change of its effective level. The request appears on `svc_valid` no earlier than the cycle after the input is sampled. The request bit is dropped in the cycle the pin is granted, whatever `dlv_ok` reports.
- R5: A level pin (`pin_trig_lvl[i]`=1) is requested in every cycle in which it is active, unmasked, granted and has its `rirr` bit clear. `dlv_ok`=1 in that cycle sets its `rirr` bit from the next cycle on. `dlv_ok`=0 leaves the bit clear, so the request repeats.
- R6: A pin whose `pin_mask` bit is 1 never appears on `svc_valid`. A masked edge pin that reaches the grant loses its request, so a later unmask does not serve it.
- R7: `eoi_valid`=1 with vector `eoi_vec` clears `rirr` of every level pin whose vector equals `eoi_vec`, from the next cycle on. Edge pins and pins with other vectors are unaffected.
- R8: A level pin released by an EOI is served again if it is still active and unmasked. A masked released pin stays unserved.
- R9: At most one pin is requested per cycle, and it is the lowest-numbered pin that needs service.
- R10: `svc_vec` equals the vector field `pin_vec[svc_pin*VW +: VW]` of the requested pin.
- R11: When an EOI clears a pin in the same cycle as a successful delivery on that pin, the delivery wins and `rirr` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_raw | input | N | Raw input level of each pin |
| pin_pol | input | N | Polarity per pin, 1 inverts the raw level |
| pin_trig_lvl | input | N | Trigger kind per pin, 1 = level, 0 = edge |
| pin_mask | input | N | Mask per pin, 1 = no delivery |
| pin_vec | input | N*VW | Vector of pin i in bits [i*VW +: VW] |
| dlv_ok | input | 1 | Dispatcher result for the current request, 1 = delivered |
| eoi_valid | input | 1 | EOI strobe |
| eoi_vec | input | VW | Vector carried by the EOI |
| svc_valid | output | 1 | Service request for pin `svc_pin` this cycle |
| svc_pin | output | $clog2(N) | Requested pin number |
| svc_vec | output | VW | Vector of the requested pin |
| rirr | output | N | Remote IRR flag of each pin |

## Verification
The assertions take the trigger kind of each pin as fixed once reset ends. If a pin changed from level to edge while its `rirr` bit was set, the flag would be left standing and the gating checks would no longer describe the block. They also assume that `dlv_ok` only matters in cycles with a request. The stimulus programs the trigger kinds before reset is released and never touches them again. It changes masks, polarity and vectors only while the affected pin is idle, and it drives `dlv_ok` freely, since it is ignored without a request.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

  // effective pin level after the polarity inversion
  function automatic logic eff_level(input logic raw, input logic pol);
    return raw ^ pol;
  endfunction

  // request bit for the next cycle
  function automatic logic next_req(input logic lvl_mode, input logic eff,
                                    input logic rise, input logic req,
                                    input logic granted);
    if (lvl_mode) return eff;
    return eff & (rise | (req & ~granted));
  endfunction

endpackage

// File: rtl/irq_pin_slot.sv
module irq_pin_slot
  import irq_trk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic pol,
  input  logic lvl_mode,
  input  logic masked,
  input  logic granted,
  input  logic dlv_ok,
  input  logic eoi_hit,
  output logic need,
  output logic rirr
);
  logic eff, lvl_q, req_q, rise;
  logic rirr_set, rirr_clr;

  assign eff  = eff_level(raw, pol);
  assign rise = eff & ~lvl_q;

  assign rirr_set = granted & lvl_mode & ~masked & dlv_ok;
  assign rirr_clr = eoi_hit & lvl_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      req_q <= 1'b0;
      rirr  <= 1'b0;
    end else begin
      lvl_q <= eff;
      req_q <= next_req(lvl_mode, eff, rise, req_q, granted);
      if (rirr_set)      rirr <= 1'b1;
      else if (rirr_clr) rirr <= 1'b0;
    end
  end

  assign need = req_q & (lvl_mode ? (~rirr & ~masked) : 1'b1);
endmodule

// File: rtl/irq_pick_lowest.sv
module irq_pick_lowest #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  need,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (need[i]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_trk.sv
module irq_trk #(
  parameter int N  = 8,
  parameter int VW = 8,
  localparam int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    pin_raw,
  input  logic [N-1:0]    pin_pol,
  input  logic [N-1:0]    pin_trig_lvl,
  input  logic [N-1:0]    pin_mask,
  input  logic [N*VW-1:0] pin_vec,
  input  logic            dlv_ok,
  input  logic            eoi_valid,
  input  logic [VW-1:0]   eoi_vec,
  output logic            svc_valid,
  output logic [IW-1:0]   svc_pin,
  output logic [VW-1:0]   svc_vec,
  output logic [N-1:0]    rirr
);
  logic [N-1:0]  need;
  logic [N-1:0]  granted;
  logic [N-1:0]  eoi_hit;
  logic          gnt_valid;
  logic [IW-1:0] gnt_idx;

  irq_pick_lowest #(.N(N)) u_pick (
    .need      (need),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign granted[i] = gnt_valid && (gnt_idx == IW'(i));
    assign eoi_hit[i] = eoi_valid && (pin_vec[i*VW +: VW] == eoi_vec);

    irq_pin_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (pin_raw[i]),
      .pol      (pin_pol[i]),
      .lvl_mode (pin_trig_lvl[i]),
      .masked   (pin_mask[i]),
      .granted  (granted[i]),
      .dlv_ok   (dlv_ok),
      .eoi_hit  (eoi_hit[i]),
      .need     (need[i]),
      .rirr     (rirr[i])
    );
  end

  assign svc_valid = gnt_valid & ~pin_mask[gnt_idx];
  assign svc_pin   = gnt_idx;
  assign svc_vec   = pin_vec[gnt_idx*VW +: VW];
endmodule

// File: rtl/irq_trk_chk.sv
module irq_trk_chk #(
  parameter int N  = 8,
  parameter int VW = 8,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  pin_mask,
  input logic          dlv_ok,
  input logic          eoi_valid,
  input logic          svc_valid,
  input logic [IW-1:0] svc_pin,
  input logic [N-1:0]  rirr,
  input logic [N-1:0]  need,
  input logic          gnt_valid,
  input logic [IW-1:0] gnt_idx
);
  // R6
  unmasked_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> !pin_mask[svc_pin]);

  // R5
  rirr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> !rirr[svc_pin]);

  // R9
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> ((need & ((N'(1) << gnt_idx) - N'(1))) == '0));

  // R5
  rirr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rirr & ~$past(rirr))) |-> $past(svc_valid && dlv_ok));

  // R9
  single_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rirr & ~$past(rirr)) <= 1);

  // R7
  rirr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~rirr & $past(rirr))) |-> $past(eoi_valid));
endmodule

bind irq_trk irq_trk_chk #(.N(N), .VW(VW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pin_mask  (pin_mask),
  .dlv_ok    (dlv_ok),
  .eoi_valid (eoi_valid),
  .svc_valid (svc_valid),
  .svc_pin   (svc_pin),
  .rirr      (rirr),
  .need      (need),
  .gnt_valid (gnt_valid),
  .gnt_idx   (gnt_idx)
);

// File: tb/sim_irq_trk.sv
module sim_irq_trk;
  localparam int N  = 8;
  localparam int VW = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    raw = '0, pol = '0, trig = '0, mask = '1;
  logic [N*VW-1:0] vecs = '0;
  logic            dlv_ok = 1'b1, eoi_valid = 1'b0;
  logic [VW-1:0]   eoi_vec = '0;
  logic            svc_valid;
  logic [IW-1:0]   svc_pin;
  logic [VW-1:0]   svc_vec;
  logic [N-1:0]    rirr;

  int checks = 0, fails = 0, cyc = 0;
  int svc_cnt[N];
  bit m_req[N], m_rirr[N], m_lvl[N];
  string tag = "R1";

  always #10 clk = ~clk;

  irq_trk #(.N(N), .VW(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_raw(raw), .pin_pol(pol),
    .pin_trig_lvl(trig), .pin_mask(mask), .pin_vec(vecs),
    .dlv_ok(dlv_ok), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
    .svc_valid(svc_valid), .svc_pin(svc_pin), .svc_vec(svc_vec),
    .rirr(rirr)
  );

  function automatic logic [VW-1:0] vec_of(int p);
    return vecs[p*VW +: VW];
  endfunction

  // lowest pin wanting attention, -1 when none
  function automatic int model_pick();
    for (int p = 0; p < N; p++) begin
      if (m_req[p]) begin
        if (!trig[p]) return p;
        if (!m_rirr[p] && !mask[p]) return p;
      end
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    int g;
    bit act;
    if (!rst_n) begin
      for (int p = 0; p < N; p++) begin
        m_req[p] = 0; m_rirr[p] = 0; m_lvl[p] = 0;
      end
    end else begin
      g = model_pick();
      for (int p = 0; p < N; p++) begin
        act = (raw[p] != pol[p]);
        if (trig[p]) m_req[p] = act;
        else if (!act) m_req[p] = 0;
        else if (!m_lvl[p]) m_req[p] = 1;
        else if (g == p) m_req[p] = 0;
        if (trig[p] && eoi_valid && vec_of(p) == eoi_vec) m_rirr[p] = 0;
        if (trig[p] && g == p && !mask[p] && dlv_ok) m_rirr[p] = 1;
        m_lvl[p] = act;
      end
    end
  end

  always @(negedge clk) begin
    int g;
    bit ev;
    logic [N-1:0] er;
    if (rst_n) begin
      g = model_pick();
      ev = (g >= 0) && !mask[g];
      for (int p = 0; p < N; p++) er[p] = m_rirr[p];
      checks++;
      if (svc_valid !== ev || rirr !== er ||
          (ev && (svc_pin !== IW'(g) || svc_vec !== vec_of(g)))) begin
        fails++;
        $display("FAIL %s cycle %0d: valid=%0b pin=%0d vec=%h rirr=%b expected valid=%0b pin=%0d vec=%h rirr=%b",
                 tag, cyc, svc_valid, svc_pin, svc_vec, rirr, ev, g,
                 (g >= 0) ? vec_of(g) : '0, er);
      end
      if (svc_valid) svc_cnt[svc_pin]++;
    end
  end

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic clr_cnt();
    for (int p = 0; p < N; p++) svc_cnt[p] = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected at most 5000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    trig = 8'b0101_1100;
    for (int p = 0; p < N; p++) vecs[p*VW +: VW] = VW'(8'h20 + p);
    vecs[2*VW +: VW] = 8'h40;
    vecs[3*VW +: VW] = 8'h40;
    vecs[4*VW +: VW] = 8'h41;
    step(3);
    // R1
    chk("R1 svc_valid in reset", svc_valid, 0);
    chk("R1 rirr in reset", rirr, 0);
    rst_n = 1'b1;
    mask = 8'b0110_0000;
    @(negedge clk); #1;
    chk("R1 svc_valid after reset", svc_valid, 0);
    step(1);

    // R4: one service per rising edge, dlv_ok ignored for edge pins
    tag = "R4"; clr_cnt();
    raw[0] = 1; step(6);
    chk("R4 one service per edge", svc_cnt[0], 1);
    raw[0] = 0; step(2);
    dlv_ok = 0; raw[0] = 1; step(6);
    chk("R4 service despite failed delivery", svc_cnt[0], 2);
    chk("R4 edge pin leaves rirr clear", rirr, 0);
    raw[0] = 0; dlv_ok = 1; step(2);

    // R2: inverted polarity pin
    tag = "R2"; clr_cnt();
    raw[1] = 1; pol[1] = 1; step(4);
    chk("R2 high raw with inversion is inactive", svc_cnt[1], 0);
    raw[1] = 0; step(4);
    chk("R2 low raw with inversion is active", svc_cnt[1], 1);

    // R5, R9, R10, R3: level pins with retry and hogging
    tag = "R5"; clr_cnt();
    dlv_ok = 0; raw[2] = 1; raw[3] = 1; step(5);
    chk("R5 level pin retried on failure", svc_cnt[2] >= 4, 1);
    chk("R9 higher pin waits", svc_cnt[3], 0);
    chk("R5 rirr clear after failures", rirr, 0);
    tag = "R3";
    raw[7] = 1; step(2); raw[7] = 0; step(2);
    tag = "R9";
    dlv_ok = 1; step(5);
    chk("R3 dropped edge request never served", svc_cnt[7], 0);
    chk("R5 rirr set on pins 2 and 3", rirr, 8'b0000_1100);
    chk("R9 pin 3 served once after pin 2", svc_cnt[3], 1);
    raw[4] = 1; step(4);
    chk("R5 rirr set on pin 4", rirr, 8'b0001_1100);

    // R7, R8: EOI releases both pins with vector 0x40
    tag = "R7"; clr_cnt();
    eoi_valid = 1; eoi_vec = 8'h40; step(1); eoi_valid = 0; step(4);
    chk("R8 pin 2 re-served after EOI", svc_cnt[2], 1);
    chk("R8 pin 3 re-served after EOI", svc_cnt[3], 1);
    chk("R7 pin 4 untouched by other vector", svc_cnt[4], 0);
    chk("R7 rirr after re-service", rirr, 8'b0001_1100);
    eoi_vec = 8'h20; eoi_valid = 1; step(1); eoi_valid = 0; step(3);
    chk("R7 EOI for edge vector has no effect", svc_cnt[0], 0);

    // R11: EOI held while the released pin is delivered again
    tag = "R11"; clr_cnt();
    eoi_vec = 8'h41; eoi_valid = 1; step(2); eoi_valid = 0; step(3);
    chk("R11 pin 4 served once", svc_cnt[4], 1);
    chk("R11 delivery wins over EOI", rirr[4], 1);

    // R6: masked pins
    tag = "R6"; clr_cnt();
    raw[5] = 1; step(3); mask[5] = 0; step(3);
    chk("R6 masked edge request discarded", svc_cnt[5], 0);
    raw[6] = 1; step(3);
    chk("R6 masked level pin not served", svc_cnt[6], 0);
    mask[6] = 0; step(3);
    chk("R6 unmasked level pin served", svc_cnt[6], 1);
    chk("R6 rirr of pin 6", rirr[6], 1);
    tag = "R8"; clr_cnt();
    mask[2] = 1; eoi_vec = 8'h40; eoi_valid = 1; step(1); eoi_valid = 0; step(4);
    chk("R8 masked released pin not served", svc_cnt[2], 0);
    chk("R8 unmasked released pin served", svc_cnt[3], 1);
    chk("R8 masked pin rirr stays clear", rirr[2], 0);
    mask[2] = 0; step(3);
    chk("R8 served after unmask", svc_cnt[2], 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule